// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block gives one cache slice a bank of eight 64-bit event counters. Each counter has a control register that holds an 8-bit event selector. From the cache pipeline the block takes a vector of single-cycle event strobes and two 8-bit occupancy values. A counter runs whenever its selector is nonzero. For a plain event code it adds one in each cycle where the chosen strobe is high. For the two occupancy codes it adds the present occupancy value on every cycle. A selector of zero freezes the counter.

Software reaches the bank through a simple 64-bit register port with a 12-bit byte address. Counter values sit in one window of 8-byte slots and selectors sit in a second window. To measure an event, software writes zero into a counter and then writes a nonzero selector. To stop the counter, it writes a selector of zero. Software adds up the results from several slices itself. Counters give no signal on overflow and simply wrap.

Top module: `evsel_ctr_bank`

## Requirements
- R1: There are eight counters, indexed 0 to 7. Counter i's value register is at byte address 0x800 + 8*i and its control register is at 0x900 + 8*i. An address is mapped only when its low three bits are zero.
- R2: A control register keeps only bits [7:0] of a write as the selector and drops the upper bits. A read returns the selector zero-extended to 64 bits.
- R3: A write to a value register loads all 64 bits. If an increment falls in the same cycle, the written value wins.
- R4: For a selector from 0x01 to 0x22, the counter adds 1 at each clock edge where strobe bit (selector − 1) of `evt_strobe` is high. Other strobe bits have no effect on it.
- R5: Selector 0x23 adds `occ_fill` at every clock edge, and selector 0x24 adds `occ_req` at every clock edge.
- R6: Selector 0x00 holds the counter at its present value whatever the strobes and occupancies do.
- R7: Selectors from 0x25 to 0xFF are stored and read back, but the counter never changes under them.
- R8: Counters wrap modulo 2^64 with no other effect.
- R9: `reg_rd_en` is sampled at a clock edge, and from that edge `reg_rdata` shows the register's value as it was before the edge. An unmapped read returns zero. `reg_rdata` holds between reads. A write to an unmapped address changes nothing.
- R10: Reset clears every counter, every selector and `reg_rdata` to zero.
- R11: Each counter follows only its own selector, so several counters can count different events at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| evt_strobe | input | 34 | Event strobes; bit k is event code k+1 |
| occ_fill | input | 8 | Fill-buffer occupancy |
| occ_req | input | 8 | Request occupancy |

## Verification
The assertions check on every cycle that a zero or unused selector freezes its counter and that a plain event code never steps a counter by more than one. They also check that register writes land with the correct width and masking, and that unmapped reads return zero. Only the bench's scenarios show the exact counts: occupancy sums, several counters running at once on different strobes, the write-versus-increment collision, the wrap past all ones, and `reg_rdata` holding between reads.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_CTR  = 2'd1,
        REG_CFG  = 2'd2
    } reg_kind_e;

    localparam logic [7:0] SEL_OFF      = 8'h00;
    localparam logic [7:0] SEL_FILL_OCC = 8'h23;
    localparam logic [7:0] SEL_REQ_OCC  = 8'h24;

endpackage

// File: rtl/evctr_addr_dec.sv
module evctr_addr_dec
    import evctr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_CTR  = 8,
    parameter int CTR_BASE = 'h800,
    parameter int CFG_BASE = 'h900,
    localparam int IDX_W   = $clog2(NUM_CTR)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int SLOT_W = ADDR_W - 3;

    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] ctr_off;
    logic [SLOT_W-1:0] cfg_off;
    logic              aligned;

    always_comb begin
        slot    = addr[ADDR_W-1:3];
        aligned = (addr[2:0] == 3'b000);
        ctr_off = slot - SLOT_W'(CTR_BASE / 8);
        cfg_off = slot - SLOT_W'(CFG_BASE / 8);
        kind    = REG_NONE;
        idx     = '0;
        if (aligned && (ctr_off < SLOT_W'(NUM_CTR))) begin
            kind = REG_CTR;
            idx  = ctr_off[IDX_W-1:0];
        end else if (aligned && (cfg_off < SLOT_W'(NUM_CTR))) begin
            kind = REG_CFG;
            idx  = cfg_off[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/evctr_evt_sel.sv
module evctr_evt_sel
    import evctr_pkg::*;
#(
    parameter int SEL_W = 8,
    parameter int EVT_W = 34,
    parameter int OCC_W = 8
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [EVT_W-1:0] strobe,
    input  logic [OCC_W-1:0] occ_fill,
    input  logic [OCC_W-1:0] occ_req,
    output logic [OCC_W-1:0] inc
);
    always_comb begin
        inc = '0;
        if (sel == SEL_W'(SEL_FILL_OCC)) begin
            inc = occ_fill;
        end else if (sel == SEL_W'(SEL_REQ_OCC)) begin
            inc = occ_req;
        end else begin
            for (int k = 0; k < EVT_W; k++) begin
                if (sel == SEL_W'(k + 1)) begin
                    inc = OCC_W'(strobe[k]);
                end
            end
        end
    end

endmodule

// File: rtl/evsel_ctr_bank.sv
module evsel_ctr_bank
    import evctr_pkg::*;
#(
    parameter int NUM_CTR  = 8,
    parameter int CTR_W    = 64,
    parameter int ADDR_W   = 12,
    parameter int SEL_W    = 8,
    parameter int EVT_W    = 34,
    parameter int OCC_W    = 8,
    parameter int CTR_BASE = 'h800,
    parameter int CFG_BASE = 'h900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CTR_W-1:0]  reg_wdata,
    output logic [CTR_W-1:0]  reg_rdata,
    input  logic [EVT_W-1:0]  evt_strobe,
    input  logic [OCC_W-1:0]  occ_fill,
    input  logic [OCC_W-1:0]  occ_req
);
    localparam int IDX_W = $clog2(NUM_CTR);

    typedef struct packed {
        logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
        logic [NUM_CTR-1:0][SEL_W-1:0] sel;
        logic [CTR_W-1:0]              rdata;
    } state_t;

    state_t state_q, state_d;

    reg_kind_e         acc_kind;
    logic [IDX_W-1:0]  acc_idx;
    logic [NUM_CTR-1:0][OCC_W-1:0] step;
    logic [NUM_CTR-1:0][CTR_W-1:0] cnt_vec;
    logic [NUM_CTR-1:0][SEL_W-1:0] sel_vec;

    evctr_addr_dec #(
        .ADDR_W  (ADDR_W),
        .NUM_CTR (NUM_CTR),
        .CTR_BASE(CTR_BASE),
        .CFG_BASE(CFG_BASE)
    ) dec_i (
        .addr(reg_addr),
        .kind(acc_kind),
        .idx (acc_idx)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_sel
        evctr_evt_sel #(
            .SEL_W(SEL_W),
            .EVT_W(EVT_W),
            .OCC_W(OCC_W)
        ) sel_i (
            .sel     (state_q.sel[g]),
            .strobe  (evt_strobe),
            .occ_fill(occ_fill),
            .occ_req (occ_req),
            .inc     (step[g])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_CTR; i++) begin
            state_d.cnt[i] = state_q.cnt[i] + CTR_W'(step[i]);
        end
        if (reg_wr_en) begin
            case (acc_kind)
                REG_CTR: state_d.cnt[acc_idx] = reg_wdata;
                REG_CFG: state_d.sel[acc_idx] = reg_wdata[SEL_W-1:0];
                default: ;
            endcase
        end
        if (reg_rd_en) begin
            case (acc_kind)
                REG_CTR: state_d.rdata = state_q.cnt[acc_idx];
                REG_CFG: state_d.rdata = CTR_W'(state_q.sel[acc_idx]);
                default: state_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rdata = state_q.rdata;
    assign cnt_vec   = state_q.cnt;
    assign sel_vec   = state_q.sel;

endmodule

// File: rtl/evctr_bank_chk.sv
module evctr_bank_chk #(
    parameter int NUM_CTR  = 8,
    parameter int CTR_W    = 64,
    parameter int ADDR_W   = 12,
    parameter int SEL_W    = 8,
    parameter int CTR_BASE = 'h800,
    parameter int CFG_BASE = 'h900
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr_en,
    input logic                          reg_rd_en,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [CTR_W-1:0]              reg_wdata,
    input logic [CTR_W-1:0]              reg_rdata,
    input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_vec,
    input logic [NUM_CTR-1:0][SEL_W-1:0] sel_vec
);
    logic [NUM_CTR-1:0] ctr_at;
    logic [NUM_CTR-1:0] cfg_at;
    logic               mapped;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        assign ctr_at[i] = (reg_addr == ADDR_W'(CTR_BASE + 8 * i));
        assign cfg_at[i] = (reg_addr == ADDR_W'(CFG_BASE + 8 * i));

        // R6
        sel_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_vec[i] == '0 && !(reg_wr_en && ctr_at[i]))
            |=> (cnt_vec[i] == $past(cnt_vec[i])));

        // R7
        sel_unused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_vec[i] > SEL_W'(8'h24) && !(reg_wr_en && ctr_at[i]))
            |=> (cnt_vec[i] == $past(cnt_vec[i])));

        // R3
        ctr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && ctr_at[i]) |=> (cnt_vec[i] == $past(reg_wdata)));

        // R2
        sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && cfg_at[i]) |=> (sel_vec[i] == $past(reg_wdata[SEL_W-1:0])));

        // R4
        single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_vec[i] != '0 && sel_vec[i] < SEL_W'(8'h23) && !(reg_wr_en && ctr_at[i]))
            |=> ((cnt_vec[i] - $past(cnt_vec[i])) <= CTR_W'(1)));
    end

    assign mapped = |{ctr_at, cfg_at};

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !mapped) |=> (reg_rdata == '0));

endmodule

bind evsel_ctr_bank evctr_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W),
    .CTR_BASE(CTR_BASE),
    .CFG_BASE(CFG_BASE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cnt_vec  (cnt_vec),
    .sel_vec  (sel_vec)
);

// File: tb/evsel_ctr_bank_tb.sv
module evsel_ctr_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [33:0] evt_strobe = '0;
    logic [7:0]  occ_fill = '0;
    logic [7:0]  occ_req = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evsel_ctr_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_strobe(evt_strobe),
        .occ_fill  (occ_fill),
        .occ_req   (occ_req)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [63:0] data;
        logic [3:0]  req;
    } vec_t;

    // read rows carry the expected value in data
    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'h918, 64'hDEAD_BEEF_0000_0041, 4'd2},
        '{1'b0, 12'h918, 64'h0000_0000_0000_0041, 4'd2},
        '{1'b1, 12'h828, 64'h1234_5678_9ABC_DEF0, 4'd3},
        '{1'b0, 12'h828, 64'h1234_5678_9ABC_DEF0, 4'd1},
        '{1'b1, 12'h80C, 64'h0000_0000_0000_00FF, 4'd9},
        '{1'b0, 12'h808, 64'h0,                   4'd9},
        '{1'b0, 12'h80C, 64'h0,                   4'd9},
        '{1'b1, 12'hA00, 64'h0000_0000_0000_0077, 4'd9},
        '{1'b0, 12'hA00, 64'h0,                   4'd9},
        '{1'b0, 12'h940, 64'h0,                   4'd1},
        '{1'b1, 12'h938, 64'h0000_0000_0000_01FF, 4'd2},
        '{1'b0, 12'h938, 64'h0000_0000_0000_00FF, 4'd2},
        '{1'b0, 12'h838, 64'h0,                   4'd1}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic reg_write(input logic [11:0] a, input logic [63:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [63:0] d);
        reg_rd_en = 1'b1;
        reg_addr  = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        idle(3);
        // R10: reset values
        check("R10 rdata after reset", reg_rdata, 64'h0);
        rst_n = 1'b1;
        reg_read(12'h800, rd); check("R10 counter0 after reset", rd, 64'h0);
        reg_read(12'h900, rd); check("R10 selector0 after reset", rd, 64'h0);

        // table walk: R1 R2 R3 R9 register map and masking
        for (int v = 0; v < NV; v++) begin
            if (TBL[v].wr) begin
                reg_write(TBL[v].addr, TBL[v].data);
            end else begin
                reg_read(TBL[v].addr, rd);
                check($sformatf("R%0d table row %0d", TBL[v].req, v), rd, TBL[v].data);
            end
        end

        // R7: counter 3 carries selector 0x41, which never counts
        reg_write(12'h818, 64'h0);
        evt_strobe = '1; occ_fill = 8'hFF; occ_req = 8'hFF;
        idle(10);
        evt_strobe = '0; occ_fill = '0; occ_req = '0;
        reg_read(12'h818, rd); check("R7 unused selector holds", rd, 64'h0);
        reg_read(12'h828, rd); check("R6 zero selector holds under activity", rd, 64'h1234_5678_9ABC_DEF0);

        // R4 and R11: three counters on different strobes
        reg_write(12'h900, 64'h01);
        reg_write(12'h908, 64'h06);
        reg_write(12'h910, 64'h22);
        evt_strobe = 34'h0 | (34'h1 << 0) | (34'h1 << 5) | (34'h1 << 33);
        idle(3);
        evt_strobe = 34'h1;
        idle(4);
        evt_strobe = '0;
        reg_read(12'h800, rd); check("R4 code 0x01 count", rd, 64'd7);
        reg_read(12'h808, rd); check("R11 code 0x06 count", rd, 64'd3);
        reg_read(12'h810, rd); check("R4 code 0x22 count", rd, 64'd3);

        // R5: occupancy accumulation
        reg_write(12'h920, 64'h23);
        reg_write(12'h930, 64'h24);
        occ_fill = 8'd5; occ_req = 8'd9;
        idle(6);
        occ_fill = '0; occ_req = '0;
        reg_read(12'h820, rd); check("R5 fill occupancy sum", rd, 64'd30);
        reg_read(12'h830, rd); check("R5 request occupancy sum", rd, 64'd54);

        // R6: zero selector halts counter 0
        reg_write(12'h900, 64'h0);
        evt_strobe = 34'h1;
        idle(5);
        evt_strobe = '0;
        reg_read(12'h800, rd); check("R6 halted counter holds", rd, 64'd7);

        // R3: write beats increment in the same cycle
        reg_write(12'h900, 64'h01);
        evt_strobe = 34'h1;
        reg_write(12'h800, 64'd100);
        evt_strobe = '0;
        reg_read(12'h800, rd); check("R3 write wins collision", rd, 64'd100);

        // R8: wrap past all ones
        reg_write(12'h800, 64'hFFFF_FFFF_FFFF_FFFF);
        evt_strobe = 34'h1;
        idle(1);
        evt_strobe = '0;
        reg_read(12'h800, rd); check("R8 wrap to zero", rd, 64'h0);

        // R9: read data holds between reads
        reg_write(12'h800, 64'd55);
        idle(1);
        check("R9 rdata holds without read", reg_rdata, 64'h0);
        reg_read(12'h800, rd); check("R3 loaded value reads back", rd, 64'd55);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule